// File: doc/BRIEF.md
# Serial Input Interrupt Detector

This block turns the input bits that a serial GPIO shift engine captures into interrupts. The engine delivers, once per completed shift frame, a strobe together with one word per bit index, where each word holds that bit index for every port. For every input pin (bit index × port) the detector keeps an enable, a two-bit trigger type, a level polarity, the pin's value in the previous frame, and a sticky pending flag.

Software programs the enables, trigger types and polarities through a narrow word-write port and clears pending flags by writing ones to the acknowledge target. The block presents, per bit index, the set of pins that are both pending and enabled, and a single interrupt line that is the OR of that set, gated by a master enable that lives in the engine's configuration logic.

Top module: `sio_irq_detect`

## Requirements
- R1: After a synchronous reset every enable, trigger type, polarity, previous-frame value and pending flag is 0, `ident_o` is all zero and `irq_o` is 0.
- R2: A write with `cfg_we` high replaces one whole word selected by `cfg_sel` (0 = enable, 1 = trigger type, 2 = polarity, 3 = acknowledge) and `cfg_idx`. For trigger type, words 0..NBIT-1 hold the low type bit of bit index `cfg_idx` and words NBIT..2*NBIT-1 hold the high type bit of bit index `cfg_idx`-NBIT; for the other targets an index of NBIT or more changes nothing. Bit position p of a word is port p.
- R3: Trigger type 0 (level): on every frame strobe where the pin is at its active level (polarity 0 = high, 1 = low) the pending flag is set, including on the first strobe after an acknowledge.
- R4: Trigger type 1 (either edge): the pending flag is set on a strobe where the pin differs from its value in the previous strobed frame.
- R5: Trigger type 2 sets pending only on a 1-to-0 change and type 3 only on a 0-to-1 change between consecutive strobed frames; polarity has no effect in these modes.
- R6: Pins are evaluated only in cycles with `frame_stb` high; input bits without a strobe change no state. The previous-frame value is 0 after reset.
- R7: Writing acknowledge with a 1 at port p of word b clears that pin's pending flag; a 0 leaves it. When a strobe sets a flag in the same cycle as its acknowledge, the flag ends up set.
- R8: `ident_o` bit b*NPORT+p is 1 exactly when pin (b,p) is pending and enabled, from the cycle after the clock edge that changed either; disabled pins still collect pending flags.
- R9: `irq_o` is registered: it is 1 in the cycle after an edge at which `irq_master_en` was 1 and `ident_o` was non-zero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse: a new captured frame is on `frame_bits` |
| frame_bits | input | NBIT*NPORT | Captured inputs, word b at bits [b*NPORT +: NPORT], port p at bit p of the word |
| cfg_we | input | 1 | Configuration word write |
| cfg_sel | input | 2 | Write target: 0 enable, 1 trigger type, 2 polarity, 3 acknowledge |
| cfg_idx | input | clog2(2*NBIT) | Word index within the target |
| cfg_wdata | input | NPORT | Word data, one bit per port |
| irq_master_en | input | 1 | Master interrupt enable |
| ident_o | output | NBIT*NPORT | Pending-and-enabled pins, same layout as `frame_bits` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checker watches on every cycle that no pending flag appears without a strobe, that none disappears without an acknowledge write, that the identity set never holds a pin that is not pending, and that the interrupt line stays low after a cycle with the master enable off and only rises after a non-empty identity set. Which trigger mode fires on which input sequence, the polarity inversion, the re-assertion of level triggers after acknowledge, the priority of a set over a simultaneous clear and the ignoring of out-of-range words can only be shown by the bench's scenarios compared against its reference model.

// File: rtl/sid_pkg.sv
package sid_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_TRIGGER  = 2'd1,
    SEL_POLARITY = 2'd2,
    SEL_ACK      = 2'd3
  } sid_sel_e;

  localparam logic [1:0] TRG_LEVEL = 2'd0;
  localparam logic [1:0] TRG_ANY   = 2'd1;
  localparam logic [1:0] TRG_FALL  = 2'd2;
  localparam logic [1:0] TRG_RISE  = 2'd3;

  // Decide whether one pin fires for the given mode and frame pair.
  function automatic logic trig_hit(input logic [1:0] mode, input logic pol,
                                    input logic cur, input logic prv);
    case (mode)
      TRG_LEVEL: return cur ^ pol;
      TRG_ANY:   return cur ^ prv;
      TRG_FALL:  return prv & ~cur;
      default:   return ~prv & cur;
    endcase
  endfunction

endpackage

// File: rtl/sid_cfg_regs.sv
module sid_cfg_regs
  import sid_pkg::*;
#(
  parameter int NBIT  = 4,
  parameter int NPORT = 32,
  parameter int IDXW  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [1:0]            sel,
  input  logic [IDXW-1:0]       idx,
  input  logic [NPORT-1:0]      wdata,
  output logic [NBIT*NPORT-1:0] en_o,
  output logic [NBIT*NPORT-1:0] tlo_o,
  output logic [NBIT*NPORT-1:0] thi_o,
  output logic [NBIT*NPORT-1:0] pol_o,
  output logic [NBIT*NPORT-1:0] ack_o
);

  for (genvar b = 0; b < NBIT; b++) begin : g_word
    localparam logic [IDXW-1:0] LO_IDX = IDXW'(b);
    localparam logic [IDXW-1:0] HI_IDX = IDXW'(NBIT + b);

    logic [NPORT-1:0] en_q, tlo_q, thi_q, pol_q;
    logic             hit_lo, hit_hi;

    assign hit_lo = we && (idx == LO_IDX);
    assign hit_hi = we && (idx == HI_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  <= '0;
        tlo_q <= '0;
        thi_q <= '0;
        pol_q <= '0;
      end else begin
        if (hit_lo && sel == SEL_ENABLE)   en_q  <= wdata;
        if (hit_lo && sel == SEL_POLARITY) pol_q <= wdata;
        if (hit_lo && sel == SEL_TRIGGER)  tlo_q <= wdata;
        if (hit_hi && sel == SEL_TRIGGER)  thi_q <= wdata;
      end
    end

    assign en_o [b*NPORT +: NPORT] = en_q;
    assign tlo_o[b*NPORT +: NPORT] = tlo_q;
    assign thi_o[b*NPORT +: NPORT] = thi_q;
    assign pol_o[b*NPORT +: NPORT] = pol_q;
    assign ack_o[b*NPORT +: NPORT] = (hit_lo && sel == SEL_ACK) ? wdata : '0;
  end

endmodule

// File: rtl/sid_word_detect.sv
module sid_word_detect
  import sid_pkg::*;
#(
  parameter int NPORT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [NPORT-1:0] cur,
  input  logic [NPORT-1:0] tlo,
  input  logic [NPORT-1:0] thi,
  input  logic [NPORT-1:0] pol,
  input  logic [NPORT-1:0] ack,
  output logic [NPORT-1:0] pend_o
);

  logic [NPORT-1:0] prev_q, pend_q, hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_pin
    assign hit[p] = stb & trig_hit({thi[p], tlo[p]}, pol[p], cur[p], prev_q[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~ack) | hit;
      if (stb) prev_q <= cur;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/sid_irq_merge.sv
module sid_irq_merge #(
  parameter int NW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] pend,
  input  logic [NW-1:0] en,
  input  logic          master,
  output logic [NW-1:0] ident_o,
  output logic          irq_o
);

  logic irq_q;

  assign ident_o = pend & en;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= master & (|ident_o);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/sio_irq_detect.sv
module sio_irq_detect #(
  parameter int NBIT  = 4,
  parameter int NPORT = 32,
  localparam int NW   = NBIT * NPORT,
  localparam int IDXW = (2 * NBIT > 2) ? $clog2(2 * NBIT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [NW-1:0]    frame_bits,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic [NPORT-1:0] cfg_wdata,
  input  logic             irq_master_en,
  output logic [NW-1:0]    ident_o,
  output logic             irq_o
);

  logic [NW-1:0] en_all, tlo_all, thi_all, pol_all, ack_all, pend_all;

  sid_cfg_regs #(.NBIT(NBIT), .NPORT(NPORT), .IDXW(IDXW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .en_o  (en_all),
    .tlo_o (tlo_all),
    .thi_o (thi_all),
    .pol_o (pol_all),
    .ack_o (ack_all)
  );

  for (genvar b = 0; b < NBIT; b++) begin : g_det
    sid_word_detect #(.NPORT(NPORT)) u_word (
      .clk    (clk),
      .rst    (rst),
      .stb    (frame_stb),
      .cur    (frame_bits[b*NPORT +: NPORT]),
      .tlo    (tlo_all[b*NPORT +: NPORT]),
      .thi    (thi_all[b*NPORT +: NPORT]),
      .pol    (pol_all[b*NPORT +: NPORT]),
      .ack    (ack_all[b*NPORT +: NPORT]),
      .pend_o (pend_all[b*NPORT +: NPORT])
    );
  end

  sid_irq_merge #(.NW(NW)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_all),
    .en      (en_all),
    .master  (irq_master_en),
    .ident_o (ident_o),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
  parameter int NW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_stb,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          irq_master_en,
  input logic [NW-1:0] pend,
  input logic [NW-1:0] ident,
  input logic          irq
);

  // R6: no flag rises in a cycle without a frame strobe
  assert_no_spont_set_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> ((pend & ~$past(pend)) == '0));

  // R7: flags fall only after an acknowledge write
  assert_clear_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == 2'd3) |=> ((~pend & $past(pend)) == '0));

  // R8: identity never reports a pin that is not pending
  assert_ident_in_pend_R8: assert property (@(posedge clk) disable iff (rst)
    ((ident & ~pend) == '0));

  // R9: master enable off forces the line low one cycle later
  assert_master_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_master_en |=> !irq);

  // R9: the line only rises after a non-empty identity set
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ident));

endmodule

bind sio_irq_detect sid_checker #(.NW(NBIT * NPORT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_stb     (frame_stb),
  .cfg_we        (cfg_we),
  .cfg_sel       (cfg_sel),
  .irq_master_en (irq_master_en),
  .pend          (pend_all),
  .ident         (ident_o),
  .irq           (irq_o)
);

// File: tb/sim_sio_irq_detect.sv
`timescale 1ns/1ps
module sim_sio_irq_detect;
  localparam int NBIT  = 4;
  localparam int NPORT = 32;
  localparam int W     = NBIT * NPORT;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic [W-1:0] frame_bits = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [NPORT-1:0] cfg_wdata = '0;
  logic irq_master_en = 1'b0;
  logic [W-1:0] ident_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_irq_detect #(.NBIT(NBIT), .NPORT(NPORT)) u0 (.*);

  // reference model state
  bit [NPORT-1:0] m_en[NBIT], m_tlo[NBIT], m_thi[NBIT], m_pol[NBIT];
  bit [NPORT-1:0] m_pend[NBIT], m_prev[NBIT];
  bit m_irq;
  bit any_id, cur, prv, hit, clr;

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBIT; b++) begin
        m_en[b] = 0; m_tlo[b] = 0; m_thi[b] = 0; m_pol[b] = 0;
        m_pend[b] = 0; m_prev[b] = 0;
      end
      m_irq = 0;
    end else begin
      any_id = 0;
      for (int b = 0; b < NBIT; b++) any_id |= |(m_pend[b] & m_en[b]);
      m_irq = irq_master_en && any_id;
      for (int b = 0; b < NBIT; b++) begin
        for (int p = 0; p < NPORT; p++) begin
          hit = 0;
          cur = frame_bits[b*NPORT + p];
          prv = m_prev[b][p];
          if (frame_stb) begin
            case ({m_thi[b][p], m_tlo[b][p]})
              2'd0: hit = (cur != m_pol[b][p]);
              2'd1: hit = (cur != prv);
              2'd2: hit = prv && !cur;
              default: hit = !prv && cur;
            endcase
            m_prev[b][p] = cur;
          end
          clr = cfg_we && cfg_sel == 2'd3 && cfg_idx == b && cfg_wdata[p];
          m_pend[b][p] = (m_pend[b][p] && !clr) || hit;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if (cfg_idx < NBIT) m_en[cfg_idx] = cfg_wdata;
          2'd1: if (cfg_idx < NBIT) m_tlo[cfg_idx] = cfg_wdata;
                else m_thi[cfg_idx - NBIT] = cfg_wdata;
          2'd2: if (cfg_idx < NBIT) m_pol[cfg_idx] = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] wv(input int b, input logic [NPORT-1:0] v);
    logic [W-1:0] r = '0;
    r[b*NPORT +: NPORT] = v;
    return r;
  endfunction

  // per-clock comparison against the model (R8 identity, R9 interrupt)
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [W-1:0] e;
      for (int b = 0; b < NBIT; b++) e[b*NPORT +: NPORT] = m_pend[b] & m_en[b];
      chk("R8 model ident", ident_o, e);
      chk("R9 model irq", W'(irq_o), W'(m_irq));
    end
  end

  task automatic step(input bit stb, input logic [W-1:0] bits, input bit we,
                      input logic [1:0] sel, input logic [IDXW-1:0] idx,
                      input logic [NPORT-1:0] data);
    @(negedge clk);
    frame_stb = stb; frame_bits = bits;
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    frame_stb = 0; cfg_we = 0;
  endtask

  task automatic idle();
    step(0, frame_bits, 0, 2'd0, '0, '0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ident", ident_o, '0);
    chk("R1 reset irq", W'(irq_o), '0);

    // level/active-high default; word 0 all high, no enables yet
    step(1, wv(0, '1), 0, 2'd0, '0, '0);
    chk("R8 pending but disabled", ident_o, '0);
    step(0, frame_bits, 1, 2'd0, 3'd4, '1);   // enable word beyond range
    chk("R2 out-of-range enable ignored", ident_o, '0);
    step(0, frame_bits, 1, 2'd0, 3'd0, 32'h0000_00FF);
    chk("R8 enable exposes pending", ident_o, wv(0, 32'hFF));
    step(0, frame_bits, 1, 2'd3, 3'd0, 32'h0000_000F);
    chk("R7 ack clears ones", ident_o, wv(0, 32'hF0));
    chk("R9 master off", W'(irq_o), '0);
    step(1, frame_bits, 0, 2'd0, '0, '0);
    chk("R3 level re-sets after ack", ident_o, wv(0, 32'hFF));
    step(0, frame_bits, 1, 2'd3, 3'd0, '0);
    chk("R7 ack of zeros no effect", ident_o, wv(0, 32'hFF));

    irq_master_en = 1;
    idle();
    chk("R9 irq raised", W'(irq_o), 1);
    step(0, '0, 1, 2'd3, 3'd0, '1);
    chk("R7 ack all", ident_o, '0);
    chk("R9 irq lags ident", W'(irq_o), 1);
    idle();
    chk("R9 irq drops", W'(irq_o), '0);

    // word 1: port0 any, port1 fall, port2 rise (pol set, ignored), port3 level low
    step(0, '0, 1, 2'd0, 3'd1, '1);
    step(0, '0, 1, 2'd1, 3'd1, 32'h5);
    step(0, '0, 1, 2'd1, 3'd5, 32'h6);
    step(0, '0, 1, 2'd2, 3'd1, 32'hC);
    step(1, wv(1, 32'h7), 0, 2'd0, '0, '0);
    chk("R4/R5 frame A", ident_o, wv(1, 32'hD));
    step(0, frame_bits, 1, 2'd3, 3'd1, '1);
    step(1, wv(1, 32'hA), 0, 2'd0, '0, '0);
    chk("R4/R5 frame B", ident_o, wv(1, 32'h1));
    step(0, frame_bits, 1, 2'd3, 3'd1, '1);
    step(1, wv(1, 32'h0), 0, 2'd0, '0, '0);
    chk("R5/R3 frame C", ident_o, wv(1, 32'hA));
    step(0, frame_bits, 1, 2'd3, 3'd1, '1);
    step(0, wv(1, 32'h5), 0, 2'd0, '0, '0);
    chk("R6 no strobe no effect", ident_o, '0);
    step(1, wv(1, 32'h0), 1, 2'd3, 3'd1, '1);
    chk("R7 set wins over ack", ident_o, wv(1, 32'h8));
    idle();
    chk("R9 irq with master on", W'(irq_o), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule